// File: doc/BRIEF.md
# Latched Fault and Alert Interrupt Controller

This block gathers the live fault conditions of a power-switch controller and the per-sample warning strobes of its monitor. It records every one of them in a sticky status bit. A set bit stays at 1 until software clears it, and a clear removes only those bits whose condition has gone away. Any fault forces a turn-off request to the power switch, and the block keeps a two-bit code naming the fault that caused the first shutdown. Warnings are recorded and can raise interrupts, but they never change the switch.

Two open-drain interrupt outputs signal the host. Each has its own source mask and its own polarity option. A pin becomes active when one of its enabled sources shows a new rising event. Each pin asserts on its own, and a clear releases both pins in the same cycle. After a clear, a condition that is still present raises no new interrupt. A monitor warning that is exceeded again on its next sample does raise a new one. The register bus is reduced to write strobes: clear-all, switch on/off command, and a per-pin mask and polarity write.

The switch control is a three-state machine:
- **SW_ON** is the reset state. It goes to SW_TRIP on any live fault, and to SW_OFF on an off command when no fault is live.
- **SW_TRIP** goes to SW_OFF only on an off command. An on command in this state is ignored.
- **SW_OFF** goes to SW_ON on an on command, and that transition also performs a clear-all.

The turn-off request is high in SW_TRIP and in SW_OFF.

Top module: `flt_alert_ctrl`

## Requirements
- R1: The status vector has bit 0 = UV fault, bit 1 = OV fault, bit 2 = OC timeout fault, bits 3..12 = warnings (3 comm error, 4 regulation timer active, 5 current over-limit, 6 current warning 2, 7 input UV, 8 input OV, 9 aux UV, 10 aux OV, 11 power over-limit, 12 FET health bad). A bit is set in the cycle after its condition is high and stays set after the condition drops, until a clear.
- R2: A clear (clear-all strobe, or an on command from SW_OFF) leaves exactly the bits whose condition is high in that cycle. A rising event in the same cycle as a clear keeps its bit set and still asserts its alert.
- R3: A live fault in SW_ON drives the turn-off request high after the next edge. No combination of warnings raises it.
- R4: The shutdown cause is encoded 00 = none, 01 = UV, 10 = OV, 11 = OC. It is captured only on a trip from SW_ON, with UV over OV over OC when faults arrive together. It then holds that first cause. It returns to 00 on a clear in which that fault is no longer live.
- R5: After reset, the status and cause are 0 and the turn-off request is 0. Both pins are released (enable 0, level 1). Pin 1 has only bit 12 enabled, pin 2 has no source enabled, and neither pin is inverted.
- R6: A pin becomes active in the cycle after a rising edge on one of its enabled sources. The two pins assert independently.
- R7: A clear makes both pins inactive in the same cycle. A condition that stays high gives no new assertion. A new rising edge, such as a warning strobe on the next sample after the clear, asserts again.
- R8: A pin with inversion set is active-high. It is released when active and pulled low (enable 1, level 0) when inactive. Without inversion, it is pulled low when active.
- R9: An off command moves SW_ON or SW_TRIP to SW_OFF. An on command in SW_TRIP has no effect. An on command in SW_OFF returns to SW_ON, clears the turn-off request and applies the clear of R2.
- R10: A configuration write with bit n of the write-enable loads the mask and inversion of pin n+1. The new mask applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_live | input | 3 | Live fault levels: UV, OV, OC timeout |
| warn_evt | input | 10 | Warning conditions or per-sample strobes (status bits 3..12) |
| clear_all | input | 1 | Clear-all command strobe |
| sw_cmd_we | input | 1 | Switch command write strobe |
| sw_cmd_on | input | 1 | Switch command value: 1 on, 0 off |
| cfg_we | input | 2 | Per-pin configuration write strobe |
| cfg_mask | input | 13 | Source enable mask to load |
| cfg_inv | input | 1 | Polarity inversion to load |
| status | output | 13 | Sticky status vector |
| sd_cause | output | 2 | Shutdown cause code |
| sw_off_req | output | 1 | Turn-off request to the power switch |
| alrt_oe | output | 2 | Per-pin pull-low enable |
| alrt_lvl | output | 2 | Resolved pin level with external pull-up |

## Verification
A vector table drives one warning that drops, a FET warning that is held, that warning held through a clear, and the same warning raised again. These patterns separate sticky bits from live levels. They also separate clearing that depends on the condition from unconditional clearing, and re-arming on an edge from re-arming on a level. Directed cases then apply simultaneous OV and OC faults followed by UV, to tell priority from first-cause hold. They apply all warnings at once, to show that no warning trips the switch. An inverted second pin driven next to the first shows independent assertion and release in the same cycle. A rising edge that coincides with a clear shows which of the two wins. An on command while tripped, and then a full off-then-on sequence, show the switch commands.

// File: rtl/flt_alert_pkg.sv
package flt_alert_pkg;
    localparam int NUM_FLT  = 3;
    localparam int NUM_WARN = 10;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_UV   = 2'b01,
        CAUSE_OV   = 2'b10,
        CAUSE_OC   = 2'b11
    } cause_e;

    typedef enum logic [1:0] {
        SW_ON   = 2'b00,
        SW_OFF  = 2'b01,
        SW_TRIP = 2'b10
    } sw_state_e;
endpackage

// File: rtl/flt_status_latch.sv
module flt_status_latch #(
    parameter int N = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cond_i,
    input  logic         clr_i,
    output logic [N-1:0] stat_o,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] cond_q;
    logic [N-1:0] stat_q;

    assign rise_o = cond_i & ~cond_q;
    assign stat_o = stat_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond_q <= '0;
            stat_q <= '0;
        end else begin
            cond_q <= cond_i;
            if (clr_i) stat_q <= cond_i;
            else       stat_q <= stat_q | cond_i;
        end
    end

    // R1
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
    // R2
    clear_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> ((stat_q & ~$past(cond_i)) == '0));
endmodule

// File: rtl/alert_pin.sv
module alert_pin #(
    parameter int           N        = 13,
    parameter logic [N-1:0] RST_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_we,
    input  logic [N-1:0] cfg_mask,
    input  logic         cfg_inv,
    input  logic [N-1:0] evt_i,
    input  logic         clr_i,
    output logic         act_o,
    output logic         oe_o
);
    logic [N-1:0] mask_q;
    logic         inv_q;
    logic         act_q;
    logic         hit;

    assign hit   = |(evt_i & mask_q);
    assign act_o = act_q;
    assign oe_o  = act_q ^ inv_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= RST_MASK;
            inv_q  <= 1'b0;
            act_q  <= 1'b0;
        end else begin
            if (cfg_we) begin
                mask_q <= cfg_mask;
                inv_q  <= cfg_inv;
            end
            act_q <= (act_q & ~clr_i) | hit;
        end
    end

    // R6
    assert_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_q) |-> $past(|(evt_i & mask_q)));
    // R7
    clear_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !(|(evt_i & mask_q))) |=> !act_q);
endmodule

// File: rtl/sw_ctrl_fsm.sv
module sw_ctrl_fsm
    import flt_alert_pkg::*;
#(
    parameter int NF = NUM_FLT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] flt_i,
    input  logic          cmd_we,
    input  logic          cmd_on,
    input  logic          clr_all_i,
    output logic          clr_o,
    output logic          off_o,
    output logic [1:0]    cause_o
);
    sw_state_e state_q, state_d;
    cause_e    cause_q;
    logic      flt_any;
    logic      restart;
    logic      cause_live;

    assign flt_any = |flt_i;
    assign restart = (state_q == SW_OFF) && cmd_we && cmd_on;
    assign clr_o   = clr_all_i | restart;
    assign cause_o = cause_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SW_ON;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SW_ON: begin
                if (flt_any)                state_d = SW_TRIP;
                else if (cmd_we && !cmd_on) state_d = SW_OFF;
            end
            SW_TRIP: if (cmd_we && !cmd_on) state_d = SW_OFF;
            SW_OFF:  if (cmd_we && cmd_on)  state_d = SW_ON;
            default: state_d = SW_ON;
        endcase
    end

    always_comb begin
        unique case (state_q)
            SW_ON:   off_o = 1'b0;
            SW_TRIP: off_o = 1'b1;
            SW_OFF:  off_o = 1'b1;
            default: off_o = 1'b1;
        endcase
    end

    always_comb begin
        unique case (cause_q)
            CAUSE_UV: cause_live = flt_i[0];
            CAUSE_OV: cause_live = flt_i[1];
            CAUSE_OC: cause_live = flt_i[2];
            default:  cause_live = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= CAUSE_NONE;
        end else if (state_q == SW_ON && flt_any && cause_q == CAUSE_NONE) begin
            if (flt_i[0])      cause_q <= CAUSE_UV;
            else if (flt_i[1]) cause_q <= CAUSE_OV;
            else               cause_q <= CAUSE_OC;
        end else if (clr_o && !cause_live) begin
            cause_q <= CAUSE_NONE;
        end
    end

    // R3
    fault_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SW_ON && flt_any) |=> off_o);
    // R4
    cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_q != CAUSE_NONE && !clr_o) |=> $stable(cause_q));
    // R9
    trip_on_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SW_TRIP && cmd_we && cmd_on) |=> (state_q == SW_TRIP));
endmodule

// File: rtl/flt_alert_ctrl.sv
module flt_alert_ctrl
    import flt_alert_pkg::*;
#(
    parameter int N_WARN = NUM_WARN,
    parameter int N_PIN  = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_FLT-1:0]          flt_live,
    input  logic [N_WARN-1:0]           warn_evt,
    input  logic                        clear_all,
    input  logic                        sw_cmd_we,
    input  logic                        sw_cmd_on,
    input  logic [N_PIN-1:0]            cfg_we,
    input  logic [NUM_FLT+N_WARN-1:0]   cfg_mask,
    input  logic                        cfg_inv,
    output logic [NUM_FLT+N_WARN-1:0]   status,
    output logic [1:0]                  sd_cause,
    output logic                        sw_off_req,
    output logic [N_PIN-1:0]            alrt_oe,
    output logic [N_PIN-1:0]            alrt_lvl
);
    localparam int N_SRC   = NUM_FLT + N_WARN;
    localparam int FET_IDX = N_SRC - 1;

    logic [N_SRC-1:0] cond;
    logic [N_SRC-1:0] rise;
    logic             clr;
    logic [N_PIN-1:0] act;

    assign cond = {warn_evt, flt_live};

    sw_ctrl_fsm #(.NF(NUM_FLT)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .flt_i     (flt_live),
        .cmd_we    (sw_cmd_we),
        .cmd_on    (sw_cmd_on),
        .clr_all_i (clear_all),
        .clr_o     (clr),
        .off_o     (sw_off_req),
        .cause_o   (sd_cause)
    );

    flt_status_latch #(.N(N_SRC)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .cond_i (cond),
        .clr_i  (clr),
        .stat_o (status),
        .rise_o (rise)
    );

    for (genvar gp = 0; gp < N_PIN; gp++) begin : g_pin
        localparam logic [N_SRC-1:0] RMASK =
            (gp == 0) ? (N_SRC'(1) << FET_IDX) : '0;
        alert_pin #(.N(N_SRC), .RST_MASK(RMASK)) u_pin (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_we   (cfg_we[gp]),
            .cfg_mask (cfg_mask),
            .cfg_inv  (cfg_inv),
            .evt_i    (rise),
            .clr_i    (clr),
            .act_o    (act[gp]),
            .oe_o     (alrt_oe[gp])
        );
        assign alrt_lvl[gp] = ~alrt_oe[gp];
    end

    // R7
    release_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act != '0 && $past(act) != '0 && (act & $past(act)) != $past(act)) |-> $past(clr));
    // R3
    off_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_off_req) |-> $past((|flt_live) || (sw_cmd_we && !sw_cmd_on)));
endmodule

// File: tb/flt_alert_ctrl_tb_top.sv
module flt_alert_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] c = '0;
    logic        clear_all = 1'b0, sw_cmd_we = 1'b0, sw_cmd_on = 1'b0, cfg_inv = 1'b0;
    logic [1:0]  cfg_we = '0;
    logic [12:0] cfg_mask = '0;
    logic [12:0] status;
    logic [1:0]  sd_cause, alrt_oe, alrt_lvl;
    logic        sw_off_req;
    int errs = 0, checks = 0;

    always #5 clk = ~clk;

    flt_alert_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .flt_live(c[2:0]), .warn_evt(c[12:3]),
        .clear_all(clear_all), .sw_cmd_we(sw_cmd_we), .sw_cmd_on(sw_cmd_on),
        .cfg_we(cfg_we), .cfg_mask(cfg_mask), .cfg_inv(cfg_inv),
        .status(status), .sd_cause(sd_cause), .sw_off_req(sw_off_req),
        .alrt_oe(alrt_oe), .alrt_lvl(alrt_lvl)
    );

    typedef struct packed {
        logic [12:0] cin;
        logic        clr;
        logic [12:0] st;
        logic [1:0]  oe;
        logic        off;
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{13'h0008, 1'b0, 13'h0008, 2'b00, 1'b0},
        '{13'h0000, 1'b0, 13'h0008, 2'b00, 1'b0},
        '{13'h1000, 1'b0, 13'h1008, 2'b01, 1'b0},
        '{13'h1000, 1'b0, 13'h1008, 2'b01, 1'b0},
        '{13'h1000, 1'b1, 13'h1000, 2'b00, 1'b0},
        '{13'h1000, 1'b0, 13'h1000, 2'b00, 1'b0},
        '{13'h0000, 1'b0, 13'h1000, 2'b00, 1'b0},
        '{13'h1000, 1'b0, 13'h1000, 2'b01, 1'b0},
        '{13'h0000, 1'b1, 13'h0000, 2'b00, 1'b0},
        '{13'h0001, 1'b0, 13'h0001, 2'b00, 1'b1}
    };

    task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic step(input logic [12:0] cv, input logic clr,
                        input logic [1:0] we, input logic [12:0] m, input logic inv,
                        input logic swe, input logic son);
        c = cv; clear_all = clr; cfg_we = we; cfg_mask = m; cfg_inv = inv;
        sw_cmd_we = swe; sw_cmd_on = son;
        @(posedge clk);
        @(negedge clk);
        clear_all = 1'b0; cfg_we = '0; sw_cmd_we = 1'b0;
    endtask

    task automatic do_reset();
        c = '0; clear_all = 0; cfg_we = '0; sw_cmd_we = 0;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #2_000_000;
        errs++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        do_reset();
        // R5 reset state
        chk("R5 status", 16'(status), 16'h0);
        chk("R5 cause", 16'(sd_cause), 16'h0);
        chk("R5 off", 16'(sw_off_req), 16'h0);
        chk("R5 oe", 16'(alrt_oe), 16'h0);
        chk("R5 lvl", 16'(alrt_lvl), 16'h3);

        // R1 R2 R6 R7 vector walk
        for (int i = 0; i < 10; i++) begin
            step(VEC[i].cin, VEC[i].clr, 2'b00, '0, 1'b0, 1'b0, 1'b0);
            chk($sformatf("R1/R2 vec%0d status", i), 16'(status), 16'(VEC[i].st));
            chk($sformatf("R6/R7 vec%0d oe", i), 16'(alrt_oe), 16'(VEC[i].oe));
            chk($sformatf("R3 vec%0d off", i), 16'(sw_off_req), 16'(VEC[i].off));
        end

        // R4 priority and first-cause hold
        do_reset();
        step(13'h0006, 0, 2'b00, '0, 0, 0, 0);
        chk("R4 OV over OC", 16'(sd_cause), 16'h2);
        chk("R3 fault trips", 16'(sw_off_req), 16'h1);
        step(13'h0001, 0, 2'b00, '0, 0, 0, 0);
        chk("R4 first cause held", 16'(sd_cause), 16'h2);
        chk("R1 status", 16'(status), 16'h0007);
        step(13'h0000, 1, 2'b00, '0, 0, 0, 0);
        chk("R4 cause cleared", 16'(sd_cause), 16'h0);
        chk("R2 status cleared", 16'(status), 16'h0);

        // R3 warnings never trip
        do_reset();
        step(13'h1FF8, 0, 2'b00, '0, 0, 0, 0);
        chk("R3 warnings no trip", 16'(sw_off_req), 16'h0);
        chk("R1 all warnings", 16'(status), 16'h1FF8);

        // R8 R10 inversion, R6 independence, R7 joint release
        do_reset();
        step(13'h0000, 0, 2'b10, 13'h0020, 1, 0, 0);
        chk("R10/R8 inv inactive oe", 16'(alrt_oe), 16'h2);
        chk("R8 inv inactive lvl", 16'(alrt_lvl), 16'h1);
        step(13'h0020, 0, 2'b00, '0, 0, 0, 0);
        chk("R6 pin2 alone", 16'(alrt_oe), 16'h0);
        step(13'h1000, 0, 2'b00, '0, 0, 0, 0);
        chk("R6 pin1 too", 16'(alrt_oe), 16'h1);
        step(13'h0000, 1, 2'b00, '0, 0, 0, 0);
        chk("R7 joint release", 16'(alrt_oe), 16'h2);
        step(13'h0020, 0, 2'b00, '0, 0, 0, 0);
        chk("R7 next sample reasserts", 16'(alrt_oe), 16'h0);

        // R2 rise wins over clear
        do_reset();
        step(13'h1000, 0, 2'b00, '0, 0, 0, 0);
        step(13'h0000, 0, 2'b00, '0, 0, 0, 0);
        step(13'h1000, 1, 2'b00, '0, 0, 0, 0);
        chk("R2 rise+clear status", 16'(status), 16'h1000);
        chk("R2 rise+clear alert", 16'(alrt_oe), 16'h1);

        // R9 off-then-on sequence
        do_reset();
        step(13'h0004, 0, 2'b00, '0, 0, 0, 0);
        chk("R4 OC code", 16'(sd_cause), 16'h3);
        step(13'h0000, 0, 2'b00, '0, 0, 0, 0);
        step(13'h0000, 0, 2'b00, '0, 0, 1, 1);
        chk("R9 on in trip ignored", 16'(sw_off_req), 16'h1);
        chk("R9 status kept", 16'(status), 16'h0004);
        step(13'h0000, 0, 2'b00, '0, 0, 1, 0);
        chk("R9 off cmd", 16'(sw_off_req), 16'h1);
        step(13'h0000, 0, 2'b00, '0, 0, 1, 1);
        chk("R9 back on", 16'(sw_off_req), 16'h0);
        chk("R9 restart clears status", 16'(status), 16'h0);
        chk("R9 restart clears cause", 16'(sd_cause), 16'h0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule